// File: doc/BRIEF.md
# Self-Test Ring Data Register

This block is a data register that can be chained with copies of itself into a closed ring for circular self-test. In normal operation it is a plain loadable register. A 2-bit mode input can switch it to three other roles: a zero initializer, which gives a known start state; a compactor, which folds its parallel input, its own contents and a serial bit from the previous ring stage into a new value; and a plain serial shifter.

In compaction mode every stage acts as a signature register and as a pattern source at the same time. After a fixed number of clocks, the ring holds a signature that depends on every response the stages absorbed. The serial output always shows the least significant bit. Wiring each stage's serial output to the next stage's serial input closes the ring.

Only system mode uses the parallel load strobe and the reset. All state changes happen on the falling clock edge.

Top module: `selftest_ring_reg`

## Requirements
- R1: The mode code is 2'b00 system, 2'b01 clear, 2'b10 compact and 2'b11 shift. The contents change only on a falling clock edge.
- R2: In system mode, a low rst_n at a falling edge clears the contents to zero. This takes priority over load.
- R3: In system mode with rst_n high, a falling edge with load high takes par_in. A falling edge with load low keeps the contents unchanged.
- R4: In clear mode, every falling edge sets the contents to all zeros, whatever par_in, load and ser_in are.
- R5: In compact mode, every falling edge sets bit i to par_in[i] XOR old bit i+1. The top bit becomes par_in[W-1] XOR ser_in.
- R6: In shift mode, every falling edge sets the contents to {ser_in, old[W-1:1]}. par_in has no effect.
- R7: par_out always equals the contents, and ser_out always equals bit 0 of the contents.
- R8: Outside system mode, rst_n and load have no effect.
- R9: In a ring of N stages of width W in shift mode, N*W falling edges bring every stage back to its starting contents. The same holds in compact mode with all parallel inputs at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on its falling edge |
| rst_n | input | 1 | Synchronous active-low clear, used in system mode only |
| mode | input | 2 | Mode code (00 system, 01 clear, 10 compact, 11 shift) |
| load | input | 1 | Parallel load strobe, used in system mode only |
| par_in | input | W | Parallel data or response word |
| ser_in | input | 1 | Serial bit from the previous ring stage |
| par_out | output | W | Current contents |
| ser_out | output | 1 | Least significant bit of the contents |

## Verification
The hardest case to reach from one stage's ports is the wrap of the serial link. A bit leaves the last stage's bottom position and enters the first stage's top position while compaction is still mixing in fresh parallel data. The bench builds a three-stage ring and preloads distinct words in system mode. It then runs long stretches of compaction with varying responses and of pure shifting, checking every stage against a reference ring model after each edge. A full rotation with zero responses must return the preloaded words exactly.

// File: rtl/ring_cell_pkg.sv
// Shared mode type for the self-test ring register.
// Assumes a 2-bit mode code driven by an external controller.
package ring_cell_pkg;
    typedef enum logic [1:0] {
        MODE_SYSTEM  = 2'b00,
        MODE_CLEAR   = 2'b01,
        MODE_COMPACT = 2'b10,
        MODE_SHIFT   = 2'b11
    } ring_mode_t;
endpackage

// File: rtl/ring_compact_net.sv
// Next-state network for compaction. Each bit takes its parallel input
// XOR its upper neighbour; the top bit takes the serial link instead.
// Purely combinational; assumes W >= 2.
module ring_compact_net #(
    parameter int W = 32
) (
    input  logic [W-1:0] par_in,
    input  logic [W-1:0] cur,
    input  logic         ser_in,
    output logic [W-1:0] nxt
);
    // Top bit folds in the previous ring stage.
    assign nxt[W-1] = par_in[W-1] ^ ser_in;

    genvar i;
    generate
        for (i = 0; i < W - 1; i++) begin : g_bit
            // Lower bits fold in the neighbour above.
            assign nxt[i] = par_in[i] ^ cur[i+1];
        end
    endgenerate
endmodule

// File: rtl/ring_shift_net.sv
// Next-state network for serial scan. The contents move one place toward
// bit 0 and the serial input enters at the top. Assumes W >= 2.
module ring_shift_net #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic         ser_in,
    output logic [W-1:0] nxt
);
    // One-place shift toward the least significant bit.
    assign nxt = {ser_in, cur[W-1:1]};
endmodule

// File: rtl/selftest_ring_reg.sv
// Multi-mode ring register for circular self-test. The mode code selects
// system load, clear, compaction or serial shift. All updates happen on
// the falling clock edge. Assumes the mode is stable around that edge;
// rst_n and load are used only in system mode.
module selftest_ring_reg
    import ring_cell_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         load,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] par_out,
    output logic         ser_out
);
    localparam logic [W-1:0] ZERO = '0;

    ring_mode_t  mode_q;
    logic [W-1:0] q;
    logic [W-1:0] nxt_compact;
    logic [W-1:0] nxt_shift;
    logic [W-1:0] nxt;

    // Decode the raw mode pins into the enum.
    assign mode_q = ring_mode_t'(mode);

    ring_compact_net #(.W(W)) u_compact (
        .par_in (par_in),
        .cur    (q),
        .ser_in (ser_in),
        .nxt    (nxt_compact)
    );

    ring_shift_net #(.W(W)) u_shift (
        .cur    (q),
        .ser_in (ser_in),
        .nxt    (nxt_shift)
    );

    // Select the next contents for the current mode.
    always_comb begin
        unique case (mode_q)
            MODE_SYSTEM:  nxt = !rst_n ? ZERO : (load ? par_in : q);
            MODE_CLEAR:   nxt = ZERO;
            MODE_COMPACT: nxt = nxt_compact;
            MODE_SHIFT:   nxt = nxt_shift;
            default:      nxt = q;
        endcase
    end

    // Contents register, updated on the falling edge.
    always_ff @(negedge clk) begin
        q <= nxt;
    end

    assign par_out = q;
    assign ser_out = q[0];

    // R3
    sys_load_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == 2'b00 && load) |=> (par_out == $past(par_in)));

    // R3
    sys_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !load) |=> $stable(par_out));

    // R4
    clear_zero_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (par_out == ZERO));

    // R5
    compact_top_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (par_out[W-1] == ($past(par_in[W-1]) ^ $past(ser_in))));

    // R5
    compact_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (par_out[0] == ($past(par_in[0]) ^ $past(par_out[1]))));

    // R6
    shift_move_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (par_out == {$past(ser_in), $past(par_out[W-1:1])}));
endmodule

// File: tb/selftest_ring_reg_bench.sv
// Three-stage ring of the register, checked against a reference ring model.
module selftest_ring_reg_bench;
    localparam int W = 32;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         load = 1'b0;
    logic [W-1:0] pin0 = '0, pin1 = '0, pin2 = '0;
    logic [W-1:0] pout0, pout1, pout2;
    logic         sout0, sout1, sout2;

    logic [W-1:0] model [N];
    logic [W-1:0] saved [N];
    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    selftest_ring_reg #(.W(W)) u_selftest_ring_reg (
        .clk(clk), .rst_n(rst_n), .mode(mode), .load(load),
        .par_in(pin0), .ser_in(sout2), .par_out(pout0), .ser_out(sout0));
    selftest_ring_reg #(.W(W)) u_stage1 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .load(load),
        .par_in(pin1), .ser_in(sout0), .par_out(pout1), .ser_out(sout1));
    selftest_ring_reg #(.W(W)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .load(load),
        .par_in(pin2), .ser_in(sout1), .par_out(pout2), .ser_out(sout2));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pin_of(input int k);
        return (k == 0) ? pin0 : (k == 1) ? pin1 : pin2;
    endfunction

    function automatic logic [W-1:0] out_of(input int k);
        return (k == 0) ? pout0 : (k == 1) ? pout1 : pout2;
    endfunction

    // One cycle: drive after the rising edge, check before and after the falling edge.
    task automatic step(input string tag, input logic [1:0] m, input logic rn, input logic ld,
                        input logic [W-1:0] p0, input logic [W-1:0] p1, input logic [W-1:0] p2);
        logic [W-1:0] nxt [N];
        @(posedge clk);
        #0.5;
        mode = m; rst_n = rn; load = ld; pin0 = p0; pin1 = p1; pin2 = p2;
        for (int k = 0; k < N; k++) begin
            logic si;
            si = model[(k + N - 1) % N][0];
            case (m)
                2'b00: nxt[k] = !rn ? '0 : (ld ? pin_of(k) : model[k]);
                2'b01: nxt[k] = '0;
                2'b10: nxt[k] = pin_of(k) ^ {si, model[k][W-1:1]};
                default: nxt[k] = {si, model[k][W-1:1]};
            endcase
        end
        #1;
        // R1: no change before the falling edge
        check({tag, " R1 before falling edge"}, pout1, model[1]);
        @(negedge clk);
        #1;
        for (int k = 0; k < N; k++) begin
            model[k] = nxt[k];
            check(tag, out_of(k), model[k]);
        end
        // R7: serial output is the low bit
        check({tag, " R7 ser_out"}, {{(W-1){1'b0}}, sout2}, {{(W-1){1'b0}}, model[2][0]});
    endtask

    task automatic t_reset();
        step("R2 reset beats load", 2'b00, 1'b0, 1'b1, 32'hDEADBEEF, 32'h1234_5678, 32'hFFFF_FFFF);
    endtask

    task automatic t_load_hold();
        step("R3 load", 2'b00, 1'b1, 1'b1, 32'h8000_0001, 32'h0F0F_F0F0, 32'hC3A5_5A3C);
        step("R3 hold", 2'b00, 1'b1, 1'b0, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
        step("R3 hold again", 2'b00, 1'b1, 1'b0, '0, '1, '0);
    endtask

    task automatic t_clear();
        step("R4 clear", 2'b01, 1'b1, 1'b1, '1, '1, '1);
        step("R3 reload", 2'b00, 1'b1, 1'b1, 32'h0000_0003, 32'hA000_0000, 32'h0001_8000);
    endtask

    task automatic t_compact();
        for (int i = 0; i < 40; i++)
            step("R5 compact", 2'b10, 1'b1, 1'b0,
                 32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 ^ (i << 5), (i % 3 == 0) ? '0 : 32'hFFFF_0000 >> i);
    endtask

    task automatic t_ignored();
        logic [W-1:0] a;
        step("R8 reset ignored in shift", 2'b11, 1'b0, 1'b1, '1, '1, '1);
        a = pout0;
        step("R8 load ignored in compact", 2'b10, 1'b0, 1'b1, '0, '0, '0);
        check("R8 not cleared", {{(W-1){1'b0}}, |(pout0 | pout1 | pout2)},
              {{(W-1){1'b0}}, |(model[0] | model[1] | model[2])});
        if (a == '0) check("R8 nonzero start", a, 32'h1);
    endtask

    task automatic t_rotate(input logic [1:0] m, input string tag);
        for (int k = 0; k < N; k++) saved[k] = model[k];
        for (int i = 0; i < N * W; i++)
            step({tag, " R6 step"}, m, 1'b1, 1'b0, '0, '0, '0);
        for (int k = 0; k < N; k++)
            check({tag, " R9 full rotation"}, out_of(k), saved[k]);
    endtask

    initial begin
        #100000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) model[k] = 'x;
        t_reset();
        t_load_hold();
        t_clear();
        t_compact();
        t_ignored();
        step("R3 preload", 2'b00, 1'b1, 1'b1, 32'hCAFE_0001, 32'h0BAD_F00D, 32'h8421_1248);
        t_rotate(2'b11, "shift");
        t_rotate(2'b10, "compact zero input");
        step("R6 shift with input", 2'b11, 1'b1, 1'b0, '1, '1, '1);
        t_compact();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule